// File: doc/BRIEF.md
# SAR ADC Serial Readout Controller

This block is the host side of a link to a single 16-bit successive-approximation converter. The converter runs in a three-wire chip-select mode and signals no completion, because its serial data input is tied high. The controller raises the convert line to start a sample. It holds that line high for a fixed worst-case conversion time, counted in system-clock cycles, and then lowers it. The falling edge makes the converter drive its most significant bit at once. The controller waits half a serial-clock period, takes that first bit, and then clocks out the remaining bits with a serial clock that it generates and that rests low.

Each incoming bit is shifted into a word, most significant bit first. When the read is done, the word is presented on a parallel output together with a one-cycle valid strobe. A conversion starts on a start request or, while the repeat input is held, by itself. Two conversions are always separated by a parameterised minimum cycle time, measured from one convert rising edge to the next. A request that arrives while a read is running or before that spacing has passed is dropped.

Top module: `sar_adc_reader`

## Requirements
- R1: While reset is applied and in the first cycle after it, the convert line, the serial clock and the valid strobe are all low.
- R2: A start request seen in idle, with the spacing satisfied, raises the convert line on the same clock edge that samples it. The line then stays high for exactly CONV_CYC cycles.
- R3: After the convert line falls, the serial clock stays low for HALF_CYC cycles and the first bit is sampled before any serial clock edge. That first bit becomes result bit 15.
- R4: The serial clock is never high while the convert line is high, and it rests low between reads.
- R5: Each read produces exactly 16 serial clock pulses, each high for HALF_CYC cycles and then low for HALF_CYC cycles. Bits 14 down to 0 are sampled at the end of the low phases that follow the first 15 falling edges. The 16 bits are assembled most significant first.
- R6: The valid strobe is high for exactly one cycle after the 16th pulse. The result holds its value until the next strobe.
- R7: While the repeat input is high, conversions restart by themselves, with convert rising edges exactly CYCLE_MIN cycles apart when a read is shorter than that.
- R8: A start request made during a read, or within CYCLE_MIN cycles of the previous convert rising edge, is ignored and not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion and readout |
| auto_i | input | 1 | Repeat conversions at the minimum cycle time while high |
| sdo_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Convert line to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| result_o | output | 16 | Last assembled conversion word |
| valid_o | output | 1 | One-cycle strobe for a new result |

## Verification
The assertions assume that the serial data input is synchronous to the system clock and already settled when the controller samples it. They also assume that reset is held for at least one clock edge. The bench's converter model changes its data output only on the falling system-clock edge after it sees the convert or serial clock line fall, so every bit is stable well before the sampling edge. Start and repeat requests are driven away from the active edge, which keeps the spacing and the ignore rules observable at the ports.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_CONV,
        RD_LEAD,
        RD_SCKH,
        RD_SCKL
    } rd_state_e;

    typedef struct packed {
        logic launch;
        logic sample;
        logic done;
    } rd_ctl_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
    import sar_rd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CONV_CYC  = 8,
    parameter int HALF_CYC  = 2,
    parameter int CYCLE_MIN = 80
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  logic    auto_i,
    output logic    cnv_o,
    output logic    sck_o,
    output rd_ctl_t ctl_o
);

    localparam int TW = $clog2(max2(CONV_CYC, HALF_CYC) + 1);
    localparam int GW = $clog2(CYCLE_MIN + 1);
    localparam int NW = $clog2(DATA_W + 1);
    localparam int HW = $clog2(CONV_CYC + 2);

    rd_state_e      state;
    logic [TW-1:0]  tmr;
    logic [GW-1:0]  gap;
    logic [NW-1:0]  npulse;
    logic           ready;
    logic           tmr_zero;
    logic           last_pulse;

    assign ready      = (gap >= GW'(CYCLE_MIN - 1));
    assign tmr_zero   = (tmr == '0);
    assign last_pulse = (npulse == NW'(DATA_W));

    always_comb begin
        ctl_o        = '0;
        ctl_o.launch = (state == RD_IDLE) && (start_i || auto_i) && ready;
        ctl_o.sample = tmr_zero && ((state == RD_LEAD) ||
                                    ((state == RD_SCKL) && !last_pulse));
        ctl_o.done   = tmr_zero && (state == RD_SCKL) && last_pulse;
    end

    assign cnv_o = (state == RD_CONV);
    assign sck_o = (state == RD_SCKH);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= GW'(CYCLE_MIN);
        end else if (ctl_o.launch) begin
            gap <= '0;
        end else if (gap != GW'(CYCLE_MIN)) begin
            gap <= gap + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RD_IDLE;
            tmr    <= '0;
            npulse <= '0;
        end else begin
            case (state)
                RD_IDLE: begin
                    if (ctl_o.launch) begin
                        state  <= RD_CONV;
                        tmr    <= TW'(CONV_CYC - 1);
                        npulse <= '0;
                    end
                end
                RD_CONV: begin
                    if (tmr_zero) begin
                        state <= RD_LEAD;
                        tmr   <= TW'(HALF_CYC - 1);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                RD_LEAD: begin
                    if (tmr_zero) begin
                        state <= RD_SCKH;
                        tmr   <= TW'(HALF_CYC - 1);
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                RD_SCKH: begin
                    if (tmr_zero) begin
                        state  <= RD_SCKL;
                        tmr    <= TW'(HALF_CYC - 1);
                        npulse <= npulse + 1'b1;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                RD_SCKL: begin
                    if (tmr_zero) begin
                        if (last_pulse) begin
                            state <= RD_IDLE;
                        end else begin
                            state <= RD_SCKH;
                            tmr   <= TW'(HALF_CYC - 1);
                        end
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    // Independent observers of the convert line for the checks below.
    logic [HW-1:0] hi_len;
    logic [GW-1:0] rise_gap;
    logic          cnv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len   <= '0;
            rise_gap <= GW'(CYCLE_MIN);
            cnv_q    <= 1'b0;
        end else begin
            cnv_q  <= cnv_o;
            hi_len <= cnv_o ? hi_len + 1'b1 : '0;
            if (cnv_o && !cnv_q) begin
                rise_gap <= GW'(1);
            end else if (rise_gap != GW'(CYCLE_MIN)) begin
                rise_gap <= rise_gap + 1'b1;
            end
        end
    end

    p_cnv_width_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cnv_o) |-> (hi_len == HW'(CONV_CYC)));

    p_first_bit_no_sck_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(cnv_o) |-> !sck_o);

    p_sck_quiet_cnv_r4: assert property (@(posedge clk) disable iff (rst)
        cnv_o |-> !sck_o);

    p_rise_spacing_r8: assert property (@(posedge clk) disable iff (rst)
        (cnv_o && !cnv_q) |-> (rise_gap >= GW'(CYCLE_MIN)));

endmodule

// File: rtl/sar_rd_shift.sv
module sar_rd_shift
    import sar_rd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_ctl_t           ctl_i,
    input  logic              sdo_i,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o
);

    localparam int NW = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] shreg;
    logic [NW-1:0]     nbits;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            nbits <= '0;
        end else if (ctl_i.launch) begin
            shreg <= '0;
            nbits <= '0;
        end else if (ctl_i.sample) begin
            shreg <= {shreg[DATA_W-2:0], sdo_i};
            nbits <= nbits + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= ctl_i.done;
            if (ctl_i.done) begin
                result_o <= shreg;
            end
        end
    end

    p_full_word_r5: assert property (@(posedge clk) disable iff (rst)
        ctl_i.done |-> (nbits == NW'(DATA_W)));

    p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader
    import sar_rd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CONV_CYC  = 8,
    parameter int HALF_CYC  = 2,
    parameter int CYCLE_MIN = 80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              auto_i,
    input  logic              sdo_i,
    output logic              cnv_o,
    output logic              sck_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o
);

    // Cycles from a convert rise back to idle; spacing below this is moot.
    localparam int READ_CYC = CONV_CYC + HALF_CYC + 2 * DATA_W * HALF_CYC;

    rd_ctl_t ctl;

    sar_rd_seq #(
        .DATA_W   (DATA_W),
        .CONV_CYC (CONV_CYC),
        .HALF_CYC (HALF_CYC),
        .CYCLE_MIN(CYCLE_MIN)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .auto_i (auto_i),
        .cnv_o  (cnv_o),
        .sck_o  (sck_o),
        .ctl_o  (ctl)
    );

    sar_rd_shift #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl),
        .sdo_i   (sdo_i),
        .result_o(result_o),
        .valid_o (valid_o)
    );

    initial begin
        if (CONV_CYC < 1 || HALF_CYC < 1 || CYCLE_MIN < 1 || READ_CYC < 1)
            $error("sar_adc_reader: timing parameters must be positive");
    end

endmodule

// File: tb/test_sar_adc_reader.sv
module test_sar_adc_reader;

    localparam int CLK_PERIOD = 10;
    localparam int CONV_CYC   = 8;
    localparam int HALF_CYC   = 2;
    localparam int CYCLE_MIN  = 80;
    localparam int NVEC       = 8;
    localparam logic [15:0] VEC [NVEC] = '{
        16'h0000, 16'hFFFF, 16'hA5C3, 16'h8001,
        16'h7FFE, 16'h1234, 16'h5555, 16'hAAAA
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        auto_i = 1'b0;
    logic        sdo_i = 1'b0;
    logic        cnv_o, sck_o, valid_o;
    logic [15:0] result_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sar_adc_reader #(
        .DATA_W(16), .CONV_CYC(CONV_CYC), .HALF_CYC(HALF_CYC), .CYCLE_MIN(CYCLE_MIN)
    ) i_sar_adc_reader (
        .clk(clk), .rst(rst), .start_i(start_i), .auto_i(auto_i), .sdo_i(sdo_i),
        .cnv_o(cnv_o), .sck_o(sck_o), .result_o(result_o), .valid_o(valid_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Converter model and line monitor, acting on the falling clock edge.
    logic [15:0] adc_word = '0;
    logic [15:0] conv_word = '0;
    int  bit_idx = 0;
    bit  prev_cnv = 0, prev_sck = 0, prev_valid = 0;
    int  cyc = 0;
    int  hi_run = 0;
    int  sck_rises = 0;
    int  rise_cnt = 0;
    int  rise_t [16];

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (cnv_o && !prev_cnv) begin
                conv_word = adc_word;
                sdo_i = 1'b0;
                sck_rises = 0;
                if (rise_cnt < 16) rise_t[rise_cnt] = cyc;
                rise_cnt++;
            end
            if (!cnv_o && prev_cnv) begin
                check(hi_run == CONV_CYC, "R2 cnv width", hi_run, CONV_CYC);
                bit_idx = 15;
                sdo_i = conv_word[15];
            end
            if (sck_o && !prev_sck) sck_rises++;
            if (!sck_o && prev_sck) begin
                bit_idx--;
                sdo_i = (bit_idx >= 0) ? conv_word[bit_idx] : 1'b0;
            end
            if (cnv_o && sck_o) check(0, "R4 sck during cnv", 1, 0);
            if (valid_o && prev_valid) check(0, "R6 valid width", 2, 1);
            hi_run = cnv_o ? hi_run + 1 : 0;
        end
        prev_cnv = cnv_o;
        prev_sck = sck_o;
        prev_valid = valid_o;
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_valid(output bit got);
        got = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (valid_o) begin
                got = 1;
                break;
            end
        end
    endtask

    task automatic run_one(input logic [15:0] w);
        bit got;
        adc_word = w;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(cnv_o == 1'b1, "R2 cnv rises on start", cnv_o, 1);
        wait_valid(got);
        check(got, "R6 valid seen", got, 1);
        check(result_o == w, "R5 word", result_o, w);
        check(result_o[15] == w[15], "R3 msb before sck", result_o[15], w[15]);
        check(sck_rises == 16, "R5 sck pulses", sck_rises, 16);
        @(negedge clk);
        check(valid_o == 1'b0 && result_o == w, "R6 one cycle and held", valid_o, 0);
        check(sck_o == 1'b0 && cnv_o == 1'b0, "R4 lines rest low", sck_o, 0);
        cycles(CYCLE_MIN);
    endtask

    initial begin
        bit got;
        int base;
        cycles(3);
        check(cnv_o == 0 && sck_o == 0 && valid_o == 0, "R1 during reset", cnv_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(cnv_o == 0 && sck_o == 0 && valid_o == 0, "R1 after reset", valid_o, 0);

        for (int v = 0; v < NVEC; v++) run_one(VEC[v]);

        // R8: start during a read is dropped
        adc_word = 16'h3C3C;
        pulse_start();
        cycles(20);
        pulse_start();
        wait_valid(got);
        check(result_o == 16'h3C3C, "R8 read unaffected", result_o, 16'h3C3C);
        base = rise_cnt;
        cycles(3 * CYCLE_MIN);
        check(rise_cnt == base, "R8 busy start not queued", rise_cnt, base);

        // R8: start inside the minimum spacing is dropped
        adc_word = 16'h0F0F;
        pulse_start();
        wait_valid(got);
        base = rise_cnt;
        pulse_start();
        cycles(2 * CYCLE_MIN);
        check(rise_cnt == base, "R8 early start ignored", rise_cnt, base);

        // R7: repeat mode
        adc_word = 16'hC001;
        base = rise_cnt;
        auto_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            wait_valid(got);
            check(result_o == adc_word, "R7 auto word", result_o, adc_word);
            if (k == 2) auto_i = 1'b0;
            adc_word = adc_word + 16'h1111;
        end
        for (int k = 1; k < 3; k++)
            check(rise_t[base + k] - rise_t[base + k - 1] == CYCLE_MIN,
                  "R7 auto spacing", rise_t[base + k] - rise_t[base + k - 1], CYCLE_MIN);
        cycles(2 * CYCLE_MIN);
        check(rise_cnt == base + 3, "R7 stops when released", rise_cnt, base + 3);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule